// File: doc/BRIEF.md
# APB Bridge to a Byte-Wide Flash Port

This block is an APB slave that gives a 32-bit bus access to an external flash device whose data path is only eight bits wide. A bus write sends its low byte to the flash in a single write strobe. A bus read runs in one of two modes, chosen by a control register. In word mode the bridge reads four consecutive bytes and packs them into one 32-bit result. In byte mode it reads a single byte and returns it zero-extended.

The bridge decodes two address windows. The flash device window covers 0xC4000000 to 0xC7FFFFFF. A small control window based at 0xC0080000 holds the read-mode register and the strobe-length register. Each flash cycle holds chip-enable and either output-enable or write-enable low for a programmable number of clocks. PREADY stays low until the last flash cycle of the transfer has ended.

Top module: `apb_flash_bridge`

## Requirements
- R1: After reset the read mode is word mode, the strobe length is 4, all flash strobes are high (inactive), and PREADY is low.
- R2: A write in the flash window produces exactly one flash cycle, with write-enable low, address PADDR[25:0] and data PWDATA[7:0].
- R3: In word mode a read in the flash window produces four flash cycles at addresses {PADDR[25:2],2'b00} plus 0, 1, 2 and 3. The byte from offset 0 lands in PRDATA[7:0] and the byte from offset 3 in PRDATA[31:24].
- R4: In byte mode a read in the flash window produces one flash cycle at PADDR[25:0]. PRDATA carries that byte in bits 7:0 and zero in bits 31:8.
- R5: The control window is matched by PADDR[31:8] == 24'hC00800. Offset 0x00 bit 0 is the read mode (0 = word, 1 = byte). Offset 0x04 bits 3:0 are the strobe length. Both registers read back what was written, with zero in the other bits. The flash window is matched by PADDR[31:26] == 6'b110001.
- R6: Each flash cycle holds chip-enable low for exactly N clocks, where N is the strobe length, or 1 when the register holds 0. The address is stable while chip-enable is low. Strobes go high for at least one clock between cycles of the same transfer.
- R7: A flash-window transfer keeps PREADY low for N+1 access-phase clocks (a write or byte read) or 4N+4 clocks (a word read), then raises it for exactly one clock with the data. A control-window or unmatched transfer completes in its first access-phase clock.
- R8: A transfer outside both windows completes at once, reads zero, starts no flash cycle, and changes no register.
- R9: Output-enable and write-enable are never low together. Chip-enable is low exactly when one of them is low.
- R10: The read mode in use is the one held when the transfer's access phase begins, so a mode change applies from the next transfer on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 32 | APB address |
| pwdata | input | 32 | APB write data |
| pready | output | 1 | Transfer complete |
| prdata | output | 32 | APB read data |
| fl_addr | output | 26 | Flash byte address |
| fl_ce_n | output | 1 | Flash chip-enable, active low |
| fl_oe_n | output | 1 | Flash output-enable, active low |
| fl_we_n | output | 1 | Flash write-enable, active low |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_dout_en | output | 1 | Drive enable for fl_dout |
| fl_din | input | 8 | Byte returned by the flash |

## Verification
A wrong byte index or base address shows up at once as a wrong value in PRDATA. The packed word is a known function of each byte address, so the bad lane can be identified. A stuck or miscounted strobe timer changes the chip-enable pulse width and the PREADY wait count within the same transfer. A burst-length error changes the number of chip-enable pulses seen before PREADY rises. A corrupted mode or strobe register shows up on the next readback, and also on the shape of the next flash transfer.

// File: rtl/flashbr_pkg.sv
package flashbr_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_GAP    = 2'd2,
    SQ_DONE   = 2'd3
  } sq_state_e;

  typedef enum logic {
    RM_WORD = 1'b0,
    RM_BYTE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/flashbr_csr.sv
module flashbr_csr
  import flashbr_pkg::*;
#(
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned WAIT_W   = 4,
  parameter int unsigned WAIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_mode,
  input  logic [WAIT_W-1:0] wr_wait,
  output logic [31:0]       rdata,
  output rd_mode_e          mode,
  output logic [WAIT_W-1:0] wait_len
);
  localparam logic [OFF_W-1:0] OFF_MODE = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] OFF_WAIT = OFF_W'(8'h04);

  rd_mode_e          mode_q, mode_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              mode_en, wait_en;

  assign mode_en = wr_en && (off == OFF_MODE);
  assign wait_en = wr_en && (off == OFF_WAIT);

  always_comb begin
    mode_d = mode_q;
    wait_d = wait_q;
    if (mode_en) mode_d = rd_mode_e'(wr_mode);
    if (wait_en) wait_d = wr_wait;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_WORD;
      wait_q <= WAIT_W'(WAIT_RST);
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (off == OFF_MODE) rdata[0] = mode_q;
    else if (off == OFF_WAIT) rdata[WAIT_W-1:0] = wait_q;
  end

  assign mode     = mode_q;
  assign wait_len = wait_q;

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(wait_q)));
endmodule

// File: rtl/flashbr_timer.sv
module flashbr_timer #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] wait_len,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q, cnt_d, eff_len;
  logic              cnt_en;

  assign eff_len = (wait_len == '0) ? WAIT_W'(1) : wait_len;
  assign cnt_en  = load || (run && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = eff_len;
    else if (run && (cnt_q != '0)) cnt_d = cnt_q - WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == WAIT_W'(1));

  assert_tmr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/flashbr_seq.sv
module flashbr_seq
  import flashbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  input  rd_mode_e          mode,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [7:0]        fl_dout,
  output logic              fl_dout_en,
  input  logic [7:0]        fl_din
);
  sq_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              wr_q, wr_d;
  logic [7:0]        wbyte_q, wbyte_d;
  logic              start, ctx_en, idx_en, cap, burst;
  logic [7:0]        lane_q [LANES];

  assign start = (st_q == SQ_IDLE) && req;
  assign burst = !is_write && (mode == RM_WORD);
  assign cap   = (st_q == SQ_STROBE) && !wr_q && tmr_expired;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    last_d   = last_q;
    base_d   = base_q;
    wr_d     = wr_q;
    wbyte_d  = wbyte_q;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    ctx_en   = 1'b0;
    idx_en   = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (req) begin
        st_d     = SQ_STROBE;
        ctx_en   = 1'b1;
        idx_en   = 1'b1;
        idx_d    = '0;
        wr_d     = is_write;
        wbyte_d  = wbyte;
        base_d   = burst ? {addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}} : addr;
        last_d   = burst ? IDX_W'(LANES-1) : '0;
        tmr_load = 1'b1;
      end
      SQ_STROBE: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          if (idx_q == last_q) st_d = SQ_DONE;
          else begin
            st_d   = SQ_GAP;
            idx_en = 1'b1;
            idx_d  = idx_q + IDX_W'(1);
          end
        end
      end
      SQ_GAP: begin
        st_d     = SQ_STROBE;
        tmr_load = 1'b1;
      end
      SQ_DONE: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      wbyte_q <= '0;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q <= idx_d;
      if (ctx_en) begin
        last_q  <= last_d;
        base_q  <= base_d;
        wr_q    <= wr_d;
        wbyte_q <= wbyte_d;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_d;
    assign lane_en = start || (cap && (idx_q == IDX_W'(g)));
    assign lane_d  = start ? 8'h00 : fl_din;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[g] <= '0;
      else if (lane_en) lane_q[g] <= lane_d;
    end
    assign rdata[8*g +: 8] = lane_q[g];
  end

  assign done       = (st_q == SQ_DONE);
  assign fl_addr    = base_q + ADDR_W'(idx_q);
  assign fl_ce_n    = (st_q != SQ_STROBE);
  assign fl_oe_n    = !((st_q == SQ_STROBE) && !wr_q);
  assign fl_we_n    = !((st_q == SQ_STROBE) && wr_q);
  assign fl_dout_en = (st_q == SQ_STROBE) && wr_q;
  assign fl_dout    = wbyte_q;

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_STROBE) |-> (idx_q <= last_q));
  assert_gap_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_GAP) |-> (fl_ce_n && fl_oe_n && fl_we_n));
endmodule

// File: rtl/apb_flash_bridge.sv
module apb_flash_bridge
  import flashbr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned WAIT_W   = 4,
  parameter int unsigned WAIT_RST = 4,
  parameter int unsigned CSR_AW   = 8,
  parameter logic [31:0] FL_BASE  = 32'hC400_0000,
  parameter logic [31:0] CSR_BASE = 32'hC008_0000
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [31:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic              pready,
  output logic [31:0]       prdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [7:0]        fl_dout,
  output logic              fl_dout_en,
  input  logic [7:0]        fl_din
);
  logic rst_meta, rst_n;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  logic        fl_hit, csr_hit, access, csr_wr, seq_done, tmr_load, tmr_run, tmr_exp;
  logic [31:0] csr_rdata, seq_rdata;
  rd_mode_e    mode;
  logic [WAIT_W-1:0] wait_len;
  logic        unused_bits;

  assign fl_hit      = (paddr[31:ADDR_W] == FL_BASE[31:ADDR_W]);
  assign csr_hit     = (paddr[31:CSR_AW] == CSR_BASE[31:CSR_AW]);
  assign access      = psel && penable;
  assign csr_wr      = access && pwrite && csr_hit;
  assign unused_bits = ^pwdata[31:8];

  flashbr_csr #(.OFF_W(CSR_AW), .WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)) csr_i (
    .clk(pclk), .rst_n(rst_n), .wr_en(csr_wr), .off(paddr[CSR_AW-1:0]),
    .wr_mode(pwdata[0]), .wr_wait(pwdata[WAIT_W-1:0]),
    .rdata(csr_rdata), .mode(mode), .wait_len(wait_len)
  );

  flashbr_timer #(.WAIT_W(WAIT_W)) tmr_i (
    .clk(pclk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
    .wait_len(wait_len), .expired(tmr_exp)
  );

  flashbr_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(pclk), .rst_n(rst_n), .req(access && fl_hit), .is_write(pwrite),
    .addr(paddr[ADDR_W-1:0]), .wbyte(pwdata[7:0]), .mode(mode),
    .tmr_expired(tmr_exp), .tmr_load(tmr_load), .tmr_run(tmr_run),
    .done(seq_done), .rdata(seq_rdata), .fl_addr(fl_addr), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_dout(fl_dout),
    .fl_dout_en(fl_dout_en), .fl_din(fl_din)
  );

  assign pready = (access && !fl_hit) || seq_done;
  always_comb begin
    prdata = '0;
    if (fl_hit) prdata = seq_rdata;
    else if (csr_hit) prdata = csr_rdata;
  end

  assert_ready_phase_R7: assert property (@(posedge pclk) disable iff (!rst_n)
    pready |-> access);
  assert_ce_match_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    (!fl_ce_n) == (!fl_oe_n || !fl_we_n));
  assert_no_strobe_idle_R8: assert property (@(posedge pclk) disable iff (!rst_n)
    (!access && fl_ce_n) |=> fl_ce_n);
endmodule

// File: tb/apb_flash_bridge_tb_top.sv
module apb_flash_bridge_tb_top;
  logic        clk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [31:0] paddr, pwdata, prdata;
  logic        pready;
  logic [25:0] fl_addr;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dout_en;
  logic [7:0]  fl_dout, fl_din;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [25:0] a);
    return a[7:0] ^ {a[15:10], a[25:24]} ^ 8'hA5;
  endfunction

  assign fl_din = fl_oe_n ? 8'hxx : fbyte(fl_addr);

  apb_flash_bridge dut_i (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pready(pready), .prdata(prdata),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din)
  );

  // flash-side monitor
  int          lowcnt = 0, seg_n = 0, width_bad = 0, overlap = 0, exp_w = 4;
  logic [25:0] seg_addr [4];
  logic [25:0] wr_a;
  logic [7:0]  wr_d;
  logic        wr_dir;

  always @(posedge clk) begin
    if (!fl_oe_n && !fl_we_n) overlap++;
    if (fl_ce_n != (fl_oe_n && fl_we_n)) overlap++;
    if (!fl_ce_n) begin
      if (lowcnt == 0) begin
        if (seg_n < 4) seg_addr[seg_n] = fl_addr;
        seg_n++;
      end
      lowcnt++;
      if (!fl_we_n) begin
        wr_a = fl_addr; wr_d = fl_dout; wr_dir = fl_dout_en;
      end
    end else if (lowcnt != 0) begin
      if (lowcnt != exp_w) width_bad++;
      lowcnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits);
    seg_n = 0; width_bad = 0;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    waits = 0;
    while (!pready && waits < 1000) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  localparam logic [31:0] CSR_MODE = 32'hC008_0000;
  localparam logic [31:0] CSR_WAIT = 32'hC008_0004;

  bit cur_byte = 0;
  int cur_n = 4;

  task automatic flash_read(input logic [31:0] a);
    logic [31:0] rd, ex;
    int w;
    logic [25:0] b;
    apb_xfer(1'b0, a, 32'h0, rd, w);
    if (cur_byte) begin
      ex = {24'h0, fbyte(a[25:0])};
      check(rd == ex, "R4", rd, ex);
      check(seg_n == 1, "R4", seg_n, 1);
      check(seg_addr[0] == a[25:0], "R4", {6'h0, seg_addr[0]}, {6'h0, a[25:0]});
      check(w == cur_n + 1, "R7", w, cur_n + 1);
    end else begin
      b = {a[25:2], 2'b00};
      ex = {fbyte(b + 26'd3), fbyte(b + 26'd2), fbyte(b + 26'd1), fbyte(b)};
      check(rd == ex, "R3", rd, ex);
      check(seg_n == 4, "R3", seg_n, 4);
      for (int i = 0; i < 4; i++)
        check(seg_addr[i] == b + 26'(i), "R3", {6'h0, seg_addr[i]}, {6'h0, b + 26'(i)});
      check(w == 4 * cur_n + 4, "R7", w, 4 * cur_n + 4);
    end
    check(width_bad == 0, "R6", width_bad, 0);
  endtask

  task automatic flash_write(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] rd;
    int w;
    apb_xfer(1'b1, a, d, rd, w);
    check(seg_n == 1, "R2", seg_n, 1);
    check(wr_a == a[25:0], "R2", {6'h0, wr_a}, {6'h0, a[25:0]});
    check(wr_d == d[7:0] && wr_dir, "R2", {23'h0, wr_dir, wr_d}, {23'h0, 1'b1, d[7:0]});
    check(w == cur_n + 1, "R7", w, cur_n + 1);
    check(width_bad == 0, "R6", width_bad, 0);
  endtask

  task automatic set_mode(input bit m);
    logic [31:0] rd;
    int w;
    apb_xfer(1'b1, CSR_MODE, {$urandom} & 32'hFFFF_FFFE | {31'h0, m}, rd, w);
    check(w == 0, "R7", w, 0);
    cur_byte = m;
    apb_xfer(1'b0, CSR_MODE, 32'h0, rd, w);
    check(rd == {31'h0, m}, "R5", rd, {31'h0, m});
  endtask

  task automatic set_wait(input int n);
    logic [31:0] rd;
    int w;
    apb_xfer(1'b1, CSR_WAIT, 32'(n), rd, w);
    cur_n = (n == 0) ? 1 : n;
    exp_w = cur_n;
    apb_xfer(1'b0, CSR_WAIT, 32'h0, rd, w);
    check(rd == 32'(n), "R5", rd, 32'(n));
  endtask

  task automatic outside(input bit wr, input logic [31:0] a);
    logic [31:0] rd, m;
    int w;
    apb_xfer(wr, a, 32'hFFFF_FFFF, rd, w);
    check(w == 0, "R8", w, 0);
    check(seg_n == 0, "R8", seg_n, 0);
    if (!wr) check(rd == 0, "R8", rd, 0);
    apb_xfer(1'b0, CSR_MODE, 32'h0, m, w);
    check(m == {31'h0, cur_byte}, "R8", m, {31'h0, cur_byte});
    apb_xfer(1'b0, CSR_WAIT, 32'h0, m, w);
    check(m[3:0] == 4'(cur_n) || (m == 0 && cur_n == 1), "R8", m, cur_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    presetn = 1'b0;
    void'($urandom(32'h1BAD_5EED));
    repeat (5) @(posedge clk);
    @(negedge clk);
    presetn = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(fl_ce_n && fl_oe_n && fl_we_n, "R1", {29'h0, fl_ce_n, fl_oe_n, fl_we_n}, 32'h7);
    check(!pready, "R1", pready, 0);
    apb_xfer(1'b0, CSR_MODE, 0, rd, w);
    check(rd == 0, "R1", rd, 0);
    apb_xfer(1'b0, CSR_WAIT, 0, rd, w);
    check(rd == 4, "R1", rd, 4);

    // directed corners
    flash_read(32'hC400_0001);       // R3 unaligned word read
    flash_read(32'hC7FF_FFFC);       // R5 top of flash window
    set_mode(1'b1);
    flash_read(32'hC7FF_FFFF);       // R4 last byte
    flash_write(32'hC400_0003, 32'h1234_56C3);
    set_wait(0);                     // R6 zero acts as one
    flash_read(32'hC400_0010);
    set_mode(1'b0);
    flash_read(32'hC400_0010);
    outside(1'b0, 32'hC800_0000);    // R8 just above flash window
    outside(1'b1, 32'hC3FF_FFFC);    // R8 just below
    outside(1'b1, 32'hC001_0000);
    // R10: mode change applies to the next transfer
    set_wait(2);
    set_mode(1'b1);
    flash_read(32'hC500_0102);
    set_mode(1'b0);
    flash_read(32'hC500_0102);

    for (int it = 0; it < 60; it++) begin
      int op;
      logic [31:0] a;
      op = $urandom_range(0, 5);
      a = 32'hC400_0000 | ($urandom & 32'h03FF_FFFF);
      case (op)
        0: set_mode(1'($urandom_range(0, 1)));
        1: set_wait($urandom_range(0, 6));
        2, 3: flash_read(a);
        4: flash_write(a, $urandom);
        default: outside(1'($urandom_range(0, 1)), $urandom & 32'h3FFF_FFFC);
      endcase
    end
    check(overlap == 0, "R9", overlap, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule